// File: doc/BRIEF.md
# UART Event and Task Register Front End

This block is the register-side controller of a UART. A simple 32-bit register bus uses write-only task registers to start and stop the transmitter and the receiver. It reads and clears four event flags: receive data ready, transmit done, line error and receive timeout. It also holds an interrupt mask with set and clear alias addresses, a sticky error-source register, four pin-routing words, a baud word and a global enable word. The whole block runs only while the enable word holds its key value.

Bytes written to the transmit-data register leave on a valid/ready byte port. One byte can be pending at a time. Bytes from the receive path land in a small FIFO, and software pops them through the receive-data register. A break pulse from the receive path marks the error source and raises the error event. One level-sensitive interrupt line combines the events through the mask.

Register map (byte addresses): tasks at 0x00 start-RX, 0x04 stop-RX, 0x08 start-TX, 0x0C stop-TX, 0x10 suspend. Events at 0x20 + 4*i, with i = 0 RX ready, 1 TX done, 2 error, 3 RX timeout. Mask bit i belongs to event i. Mask at 0x40, set alias at 0x44, clear alias at 0x48, error source at 0x4C, enable at 0x50, pin words at 0x54..0x60, baud at 0x64, receive data at 0x68, transmit data at 0x6C. Read data is combinational while the read strobe is high. A task acts only on a written value of exactly 1. Unmapped addresses and write-only registers read 0. Writes to unmapped addresses are dropped.

Top module: `uart_evtask_regs`

## Requirements
- R1: Writing exactly 4 to the enable word (0x50) enables the block. Any other nonzero value leaves the enable state unchanged.
- R2: Writing 0 to the enable word disables the block, clears the TX-started and RX-started states, and sets the RX-timeout event (index 3).
- R3: While disabled, every read returns 0 and every write except one to the enable word has no effect.
- R4: `irq` is high exactly when some event flag i is set and mask bit i is 1.
- R5: A write to 0x44 ORs the data into the mask. A write to 0x48 clears the mask bits given as 1. A write to 0x40 loads the mask. A read of any of the three addresses returns the mask in bits 3:0.
- R6: The error source (0x4C) is write-one-to-clear. A break pulse sets its bits 1:0 and the error event. In the same cycle as a clearing write, the break wins.
- R7: A transmit-data write is taken only when TX is started and no byte is pending. `tx_data` holds until the handshake. The handshake clears pending and sets the TX-done event, which wins over a software clear in the same cycle.
- R8: Stop-TX clears only TX-started. Stop-RX clears RX-started and sets RX timeout. Suspend clears both and sets RX timeout.
- R9: After reset the pin words read 0xFFFFFFFF and the baud word reads 0x04000000. Mask, events, error source, enable and started states are zero.
- R10: `rx_ready` is high only while RX is started and the FIFO is not full. An accepted byte sets RX ready. A read of 0x68 returns the oldest byte and pops it, and sets RX ready again if bytes remain.
- R11: Writing an event address loads its flag from data bit 0, and a read returns the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| rx_break | input | 1 | Break detected on the line, one-cycle pulse |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions between hardware and software can land on the same clock edge. In the first, the serializer handshake meets a software write that clears the TX-done event. In the second, a break pulse meets a write-one-to-clear of the error source. The bench forces each collision by raising `tx_ready` or `rx_break` at the same falling edge that presents the clearing write. It then reads the register back and expects the hardware set to have won: TX done reads 1 and the error source reads 3. The transmitted bytes are scored against a queue. A byte that was wrongly accepted while another was pending would show up there as a mismatch.

// File: rtl/uart_evt_pkg.sv
`timescale 1ns/1ps
package uart_evt_pkg;
  localparam int REG_AW = 8;
  localparam int EVT_N  = 4;
  localparam int ERR_W  = 4;
  localparam int PIN_N  = 4;

  localparam int EV_RXRDY = 0;
  localparam int EV_TXDONE = 1;
  localparam int EV_ERROR = 2;
  localparam int EV_RXTO  = 3;

  localparam logic [REG_AW-1:0] OFF_START_RX = 8'h00;
  localparam logic [REG_AW-1:0] OFF_STOP_RX  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_START_TX = 8'h08;
  localparam logic [REG_AW-1:0] OFF_STOP_TX  = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_SUSPEND  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_EVT0     = 8'h20;
  localparam logic [REG_AW-1:0] OFF_MASK     = 8'h40;
  localparam logic [REG_AW-1:0] OFF_MASK_SET = 8'h44;
  localparam logic [REG_AW-1:0] OFF_MASK_CLR = 8'h48;
  localparam logic [REG_AW-1:0] OFF_ERRSRC   = 8'h4C;
  localparam logic [REG_AW-1:0] OFF_ENABLE   = 8'h50;
  localparam logic [REG_AW-1:0] OFF_PIN0     = 8'h54;
  localparam logic [REG_AW-1:0] OFF_BAUD     = 8'h64;
  localparam logic [REG_AW-1:0] OFF_RXDATA   = 8'h68;
  localparam logic [REG_AW-1:0] OFF_TXDATA   = 8'h6C;

  localparam logic [31:0] ENABLE_KEY = 32'd4;
  localparam logic [31:0] PIN_RST    = 32'hFFFF_FFFF;
  localparam logic [31:0] BAUD_RST   = 32'h0400_0000;

  function automatic logic [REG_AW-1:0] evt_off(input int i);
    return REG_AW'(OFF_EVT0 + REG_AW'(4 * i));
  endfunction

  function automatic logic [REG_AW-1:0] pin_off(input int k);
    return REG_AW'(OFF_PIN0 + REG_AW'(4 * k));
  endfunction
endpackage

// File: rtl/uart_evt_rxfifo.sv
`timescale 1ns/1ps
module uart_evt_rxfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/uart_evt_txhold.sv
`timescale 1ns/1ps
module uart_evt_txhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] dout,
  input  logic         ready,
  output logic         done
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;

  assign done = vld_q & ready;

  always_comb begin
    vld_d = vld_q;
    if (done) vld_d = 1'b0;
    if (load) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (load) dat_q <= din;
  end

  assign valid = vld_q;
  assign dout  = dat_q;
endmodule

// File: rtl/uart_evt_irq.sv
`timescale 1ns/1ps
module uart_evt_irq #(
  parameter int N = 4
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] term;
  for (genvar g = 0; g < N; g++) begin : g_term
    assign term[g] = evt[g] & mask[g];
  end
  assign irq = |term;
endmodule

// File: rtl/uart_evtask_regs.sv
`timescale 1ns/1ps
module uart_evtask_regs
  import uart_evt_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int DW       = 32,
  parameter int BW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              tx_valid,
  output logic [BW-1:0]     tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BW-1:0]     rx_data,
  output logic              rx_ready,
  input  logic              rx_break,
  output logic              irq
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic              en_q, en_d;
  logic              txs_q, txs_d;
  logic              rxs_q, rxs_d;
  logic [EVT_N-1:0]  evt_q, evt_d;
  logic [EVT_N-1:0]  mask_q, mask_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic [DW-1:0]     pin_q [PIN_N];
  logic [DW-1:0]     pin_d [PIN_N];
  logic [DW-1:0]     baud_q, baud_d;

  logic              wr_ok, is_one;
  logic              tx_load, tx_done;
  logic              rx_push, rx_pop;
  logic              fifo_full, fifo_empty;
  logic [CW-1:0]     fifo_cnt;
  logic [BW-1:0]     rx_head;

  assign wr_ok   = bus_wr && (en_q || bus_addr == OFF_ENABLE);
  assign is_one  = (bus_wdata == DW'(1));
  assign tx_load = wr_ok && en_q && bus_addr == OFF_TXDATA && txs_q && !tx_valid;
  assign rx_ready = rxs_q && !fifo_full;
  assign rx_push = rx_valid && rx_ready;
  assign rx_pop  = bus_rd && en_q && bus_addr == OFF_RXDATA && rxs_q && !fifo_empty;

  uart_evt_rxfifo #(.DEPTH(RX_DEPTH), .W(BW)) u_rxfifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (rx_pop),
    .dout  (rx_head),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_evt_txhold #(.W(BW)) u_txhold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tx_load),
    .din   (bus_wdata[BW-1:0]),
    .valid (tx_valid),
    .dout  (tx_data),
    .ready (tx_ready),
    .done  (tx_done)
  );

  uart_evt_irq #(.N(EVT_N)) u_irq (
    .evt  (evt_q),
    .mask (mask_q),
    .irq  (irq)
  );

  // Next state: software writes first, hardware sets afterwards so they win.
  always_comb begin
    en_d   = en_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    evt_d  = evt_q;
    mask_d = mask_q;
    err_d  = err_q;
    baud_d = baud_q;
    for (int k = 0; k < PIN_N; k++) pin_d[k] = pin_q[k];

    if (wr_ok) begin
      case (bus_addr)
        OFF_START_RX: if (is_one) rxs_d = 1'b1;
        OFF_START_TX: if (is_one) txs_d = 1'b1;
        OFF_STOP_TX:  if (is_one) txs_d = 1'b0;
        OFF_STOP_RX: begin
          if (is_one) begin
            rxs_d = 1'b0;
            evt_d[EV_RXTO] = 1'b1;
          end
        end
        OFF_SUSPEND: begin
          if (is_one) begin
            txs_d = 1'b0;
            rxs_d = 1'b0;
            evt_d[EV_RXTO] = 1'b1;
          end
        end
        OFF_MASK:     mask_d = bus_wdata[EVT_N-1:0];
        OFF_MASK_SET: mask_d = mask_q | bus_wdata[EVT_N-1:0];
        OFF_MASK_CLR: mask_d = mask_q & ~bus_wdata[EVT_N-1:0];
        OFF_ERRSRC:   err_d  = err_q & ~bus_wdata[ERR_W-1:0];
        OFF_ENABLE: begin
          if (bus_wdata == '0) begin
            en_d  = 1'b0;
            txs_d = 1'b0;
            rxs_d = 1'b0;
            evt_d[EV_RXTO] = 1'b1;
          end else if (bus_wdata == DW'(ENABLE_KEY)) begin
            en_d = 1'b1;
          end
        end
        OFF_BAUD:     baud_d = bus_wdata;
        default: begin
          for (int i = 0; i < EVT_N; i++)
            if (bus_addr == evt_off(i)) evt_d[i] = bus_wdata[0];
          for (int k = 0; k < PIN_N; k++)
            if (bus_addr == pin_off(k)) pin_d[k] = bus_wdata;
        end
      endcase
    end

    if (tx_done) evt_d[EV_TXDONE] = 1'b1;
    if (rx_break) begin
      err_d[1:0] = 2'b11;
      evt_d[EV_ERROR] = 1'b1;
    end
    if (rx_pop && fifo_cnt > CW'(1)) evt_d[EV_RXRDY] = 1'b1;
    if (rx_push) evt_d[EV_RXRDY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      txs_q  <= 1'b0;
      rxs_q  <= 1'b0;
      evt_q  <= '0;
      mask_q <= '0;
      err_q  <= '0;
      baud_q <= DW'(BAUD_RST);
      for (int k = 0; k < PIN_N; k++) pin_q[k] <= DW'(PIN_RST);
    end else begin
      en_q   <= en_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      evt_q  <= evt_d;
      mask_q <= mask_d;
      err_q  <= err_d;
      baud_q <= baud_d;
      for (int k = 0; k < PIN_N; k++) pin_q[k] <= pin_d[k];
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (en_q) begin
      case (bus_addr)
        OFF_MASK, OFF_MASK_SET, OFF_MASK_CLR: bus_rdata = DW'(mask_q);
        OFF_ERRSRC: bus_rdata = DW'(err_q);
        OFF_ENABLE: bus_rdata = DW'(ENABLE_KEY);
        OFF_BAUD:   bus_rdata = baud_q;
        OFF_RXDATA: bus_rdata = DW'(rx_head);
        default: begin
          for (int i = 0; i < EVT_N; i++)
            if (bus_addr == evt_off(i)) bus_rdata = DW'(evt_q[i]);
          for (int k = 0; k < PIN_N; k++)
            if (bus_addr == pin_off(k)) bus_rdata = pin_q[k];
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_evtask_chk.sv
`timescale 1ns/1ps
module uart_evtask_chk
  import uart_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_break,
  input logic              irq,
  input logic [EVT_N-1:0]  evt,
  input logic [EVT_N-1:0]  mask,
  input logic [ERR_W-1:0]  err_src,
  input logic              en,
  input logic              tx_started,
  input logic              rx_started
);
  // R1
  enable_key_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_ENABLE && bus_wdata != 32'd0 && bus_wdata != 32'd4)
      |=> (en == $past(en)));

  // R2
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_ENABLE && bus_wdata == 32'd0)
      |=> (!en && !tx_started && !rx_started && evt[EV_RXTO]));

  // R3
  disabled_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && bus_wr && bus_addr != OFF_ENABLE) |=> $stable(mask));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R4
  irq_rx_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[EV_RXRDY] && mask[EV_RXRDY]) |-> irq);

  // R6
  break_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (evt[EV_ERROR] && err_src[1:0] == 2'b11));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7
  tx_done_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (evt[EV_TXDONE] && !tx_valid));

  // R10
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_started |-> !rx_ready);

  // R10
  rx_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> evt[EV_RXRDY]);
endmodule

bind uart_evtask_regs uart_evtask_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_break   (rx_break),
  .irq        (irq),
  .evt        (evt_q),
  .mask       (mask_q),
  .err_src    (err_q),
  .en         (en_q),
  .tx_started (txs_q),
  .rx_started (rxs_q)
);

// File: tb/uart_evtask_regs_tb.sv
`timescale 1ns/1ps
module uart_evtask_regs_tb;
  import uart_evt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready, rx_break;
  logic [7:0]  rx_data;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  uart_evtask_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_break(rx_break), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(OFF_TXDATA, {24'd0, b});
  endtask

  // Scoreboard monitor for the transmit port (R7)
  always begin
    @(negedge clk);
    #1;
    if (rst_n === 1'b1 && tx_valid && tx_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R7 unexpected byte actual=%h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          n_err++;
          $display("FAIL R7 tx byte actual=%h expected=%h", tx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_break = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 irq after reset", {31'd0, irq}, 32'd0);
    check("R9 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
    check("R9 rx_ready after reset", {31'd0, rx_ready}, 32'd0);

    rd(OFF_PIN0, v);      check("R3 disabled read", v, 32'd0);
    wr(OFF_MASK, 32'hF);  // ignored while disabled
    wr(OFF_ENABLE, 32'd5);
    rd(OFF_BAUD, v);      check("R1 non-key keeps disabled", v, 32'd0);
    wr(OFF_ENABLE, 32'd4);
    rd(OFF_BAUD, v);      check("R9 baud reset", v, 32'h0400_0000);
    rd(pin_off(3), v);    check("R9 pin reset", v, 32'hFFFF_FFFF);
    rd(OFF_MASK, v);      check("R3 write ignored while disabled", v, 32'd0);
    rd(OFF_ERRSRC, v);    check("R9 errsrc reset", v, 32'd0);

    // R5 mask aliases
    wr(OFF_MASK, 32'h1);
    wr(OFF_MASK_SET, 32'h4);
    rd(OFF_MASK, v);      check("R5 set alias", v, 32'h5);
    wr(OFF_MASK_CLR, 32'h1);
    rd(OFF_MASK_CLR, v);  check("R5 clear alias readback", v, 32'h4);

    // R11 / R4 direct event writes
    wr(evt_off(1), 32'h1);
    rd(evt_off(1), v);    check("R11 event write", v, 32'h1);
    check("R4 masked-off event", {31'd0, irq}, 32'd0);
    wr(OFF_MASK_SET, 32'h2);
    check("R4 enabled event", {31'd0, irq}, 32'd1);
    wr(evt_off(1), 32'h0);
    check("R11 event clear", {31'd0, irq}, 32'd0);

    // R7 transmit
    wr(OFF_TXDATA, 32'h77);
    check("R7 not started", {31'd0, tx_valid}, 32'd0);
    wr(OFF_START_TX, 32'd1);
    tx_send(8'hA5);
    check("R7 pending", {31'd0, tx_valid}, 32'd1);
    wr(OFF_TXDATA, 32'h3C);
    check("R7 pending write ignored", {24'd0, tx_data}, 32'hA5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    #1 check("R7 pending cleared", {31'd0, tx_valid}, 32'd0);
    rd(evt_off(1), v);    check("R7 tx done event", v, 32'd1);
    wr(evt_off(1), 32'h0);
    tx_send(8'h5A);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = evt_off(1); bus_wdata = 32'd0; tx_ready = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tx_ready = 1'b0;
    rd(evt_off(1), v);    check("R7 handshake beats clear", v, 32'd1);
    check("R7 scoreboard drained", exp_q.size(), 32'd0);

    // R10 receive
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h10;
    #1 check("R10 not started", {31'd0, rx_ready}, 32'd0);
    @(negedge clk); rx_valid = 1'b0;
    wr(OFF_START_RX, 32'd1);
    rx_send(8'h11); rx_send(8'h22);
    rd(evt_off(0), v);    check("R10 rx ready event", v, 32'd1);
    wr(evt_off(0), 32'd0);
    rd(OFF_RXDATA, v);    check("R10 oldest byte", v, 32'h11);
    rd(evt_off(0), v);    check("R10 event re-raised", v, 32'd1);
    wr(evt_off(0), 32'd0);
    rd(OFF_RXDATA, v);    check("R10 second byte", v, 32'h22);
    rd(evt_off(0), v);    check("R10 event stays clear", v, 32'd0);
    for (int i = 0; i < 4; i++) rx_send(8'h31 + 8'(i));
    check("R10 full", {31'd0, rx_ready}, 32'd0);
    rx_send(8'h99);
    for (int i = 0; i < 4; i++) begin
      rd(OFF_RXDATA, v);  check("R10 fifo order", v, 32'h31 + 32'(i));
    end
    check("R10 ready again", {31'd0, rx_ready}, 32'd1);

    // R6 break and error source
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd(OFF_ERRSRC, v);    check("R6 break bits", v, 32'h3);
    rd(evt_off(2), v);    check("R6 error event", v, 32'd1);
    check("R4 error term", {31'd0, irq}, 32'd1);
    wr(OFF_ERRSRC, 32'h1);
    rd(OFF_ERRSRC, v);    check("R6 w1c", v, 32'h2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = OFF_ERRSRC; bus_wdata = 32'h3; rx_break = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_break = 1'b0;
    rd(OFF_ERRSRC, v);    check("R6 break beats clear", v, 32'h3);
    wr(evt_off(2), 32'd0);

    // R8 tasks
    wr(OFF_STOP_TX, 32'd1);
    wr(OFF_TXDATA, 32'h44);
    check("R8 stop tx", {31'd0, tx_valid}, 32'd0);
    check("R8 rx untouched", {31'd0, rx_ready}, 32'd1);
    rd(evt_off(3), v);    check("R8 no timeout on stop tx", v, 32'd0);
    wr(OFF_STOP_RX, 32'd1);
    check("R8 stop rx", {31'd0, rx_ready}, 32'd0);
    rd(evt_off(3), v);    check("R8 timeout on stop rx", v, 32'd1);
    wr(evt_off(3), 32'd0);
    wr(OFF_START_TX, 32'd1);
    wr(OFF_START_RX, 32'd1);
    wr(OFF_SUSPEND, 32'd1);
    check("R8 suspend rx", {31'd0, rx_ready}, 32'd0);
    rd(evt_off(3), v);    check("R8 suspend timeout", v, 32'd1);
    wr(OFF_TXDATA, 32'h45);
    check("R8 suspend tx", {31'd0, tx_valid}, 32'd0);
    wr(evt_off(3), 32'd0);

    // R2 disable
    wr(OFF_START_TX, 32'd1);
    wr(OFF_START_RX, 32'd1);
    wr(OFF_MASK_SET, 32'h8);
    wr(OFF_ENABLE, 32'd0);
    check("R2 timeout raises irq", {31'd0, irq}, 32'd1);
    check("R2 rx stopped", {31'd0, rx_ready}, 32'd0);
    rd(OFF_MASK, v);      check("R3 read zero when disabled", v, 32'd0);
    wr(OFF_ENABLE, 32'd4);
    rd(evt_off(3), v);    check("R2 timeout event", v, 32'd1);
    wr(OFF_TXDATA, 32'h55);
    check("R2 tx stopped", {31'd0, tx_valid}, 32'd0);
    rd(OFF_MASK, v);      check("R5 mask kept", v, 32'hE);

    repeat (4) @(negedge clk);
    check("R7 no stray bytes", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule